// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block sits on the device side of a 16-bit parallel NOR flash. It watches host write cycles, each an address and a data word, and turns them into commands. Some commands take one cycle. Others take two cycles: a setup byte followed by a confirm byte or a sub-opcode. One more command is a counted buffered-program sequence. The block keeps track of which read source the array output mux should use: array, identifier, query table or status. It keeps the sticky error bits of the status byte. It also sends one-cycle operation pulses, carrying an address and a data word, to an array back end that is modelled elsewhere.

Buffered program data goes into a local word buffer. The back end drains it through an index port once the sequence has been confirmed. Only the low data byte is decoded as a command. The full word is kept only where it is the payload.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `read_mode_o` is 0 (array), `op_valid_o` is low, and status error bits 5 and 4 are clear.
- R2: In idle, the low data byte selects the read mode, which appears on `read_mode_o` one cycle after the write: 0xFF gives 0 (array), 0x90 gives 1 (identifier), 0x98 gives 2 (query) and 0x70 gives 3 (status). Data bits 15:8 take no part in decoding.
- R3: In idle, 0x50 clears status bits 5 and 4 and leaves the read mode unchanged.
- R4: Word program works as follows. A 0x40 cycle moves the read mode to status. A second cycle at the same address then pulses op code 1, with that address and the full data word.
- R5: Erase and blank check each take a setup byte and a 0xD0 confirm at the same address. Erase uses 0x20 and pulses op code 2. Blank check uses 0xBC and pulses op code 3. Each pulse carries the address and data 0. The setup cycle moves the read mode to status.
- R6: After a 0x60 prefix, a second cycle at the same address picks the operation and pulses it with data 0, except where noted. 0x01 locks (op 4). 0xD0 unlocks (op 5). 0x2F locks down (op 6). 0x03 writes the read configuration (op 7), and its op data is address bits 16:1. The read mode is left unchanged.
- R7: In idle, 0xB0 pulses suspend (op 10) and 0xD0 pulses resume (op 11). Both carry the address, and both move the read mode to status.
- R8: A 0xC0 setup followed by a second cycle at the same address pulses one-time-programmable or lock register program (op 8), with the address and the full data word.
- R9: Buffered program runs as follows. A 0xE8 cycle is followed by a count cycle at the same address carrying N-1. Then come N data cycles, which fill buffer entries 0 to N-1 in order. A 0xD0 confirm then pulses op code 9. Its address is the address of the first data cycle and its data is N-1. The stored words can be read back on `buf_rd_data_o`.
- R10: A bad second cycle aborts the sequence. A bad second cycle is a wrong confirm or sub-opcode, an address that differs from the setup cycle, or a non-0xD0 buffered confirm. The abort sends no op, sets status bit 4, sets the read mode to status, and returns the block to idle.
- R11: A count cycle carrying a value of `BUF_DEPTH` or more sets status bit 5 and sends no op. It leaves every buffer entry unchanged, sets the read mode to status, and returns the block to idle.
- R12: Status bit 7 is the inverse of `busy_i` in the same cycle. Bits 6, 3, 2, 1 and 0 are zero.
- R13: `op_valid_o` is high for exactly the one cycle after the write that completes a command. An idle data byte that is not a command changes neither the read mode nor the status, and sends no op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write cycle strobe, one clock per cycle |
| addr_i | input | ADDR_W | Write cycle address |
| data_i | input | 16 | Write cycle data |
| busy_i | input | 1 | Back end busy flag |
| read_mode_o | output | 2 | Read source select: 0 array, 1 identifier, 2 query, 3 status |
| status_o | output | 8 | Status byte: bit 7 ready, bit 5 count error, bit 4 sequence error |
| op_valid_o | output | 1 | Operation pulse |
| op_code_o | output | 4 | Operation code (see R4 to R9) |
| op_addr_o | output | ADDR_W | Operation address |
| op_data_o | output | 16 | Operation data |
| buf_rd_idx_i | input | IDX_W | Program buffer read index |
| buf_rd_data_o | output | 16 | Program buffer read data |

## Verification
The bench builds the block with `BUF_DEPTH` = 8 and the default 25-bit address. With that depth, a full buffer (count 7) and the first rejected count (8) can both be driven in a handful of cycles. The same holds for the single-word case, so both edges of the count check and the complete buffer readback are exercised. The address width keeps bits 16:1 available, so the read-configuration payload is checked against a chosen address pattern.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_ID     = 2'd1,
    RM_QUERY  = 2'd2,
    RM_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_PROG     = 4'd1,
    OP_ERASE    = 4'd2,
    OP_BLANK    = 4'd3,
    OP_LOCK     = 4'd4,
    OP_UNLOCK   = 4'd5,
    OP_LOCKDOWN = 4'd6,
    OP_RDCFG    = 4'd7,
    OP_OTP      = 4'd8,
    OP_BUFPROG  = 4'd9,
    OP_SUSPEND  = 4'd10,
    OP_RESUME   = 4'd11
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_ERASE, S_BLANK, S_CFG, S_OTP, S_BCNT, S_BDATA, S_BCONF
  } seq_st_e;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_ID      = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_WPROG   = 8'h40;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_BLANK   = 8'hBC;
  localparam logic [7:0] C_CFG     = 8'h60;
  localparam logic [7:0] C_OTP     = 8'hC0;
  localparam logic [7:0] C_BUF     = 8'hE8;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LOCK    = 8'h01;
  localparam logic [7:0] C_LOCKDN  = 8'h2F;
  localparam logic [7:0] C_RDCFG   = 8'h03;

endpackage

// File: rtl/nor_wbuf.sv
module nor_wbuf #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [15:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [15:0]      rd_data_o
);

  logic [15:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/nor_status_reg.sv
module nor_status_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       set_seq_i,
  input  logic       set_cnt_i,
  input  logic       clr_i,
  output logic [7:0] status_o
);

  logic seq_err_q, cnt_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_err_q <= 1'b0;
      cnt_err_q <= 1'b0;
    end else if (clr_i) begin
      seq_err_q <= 1'b0;
      cnt_err_q <= 1'b0;
    end else begin
      if (set_seq_i) seq_err_q <= 1'b1;
      if (set_cnt_i) cnt_err_q <= 1'b1;
    end
  end

  assign status_o = {~busy_i, 1'b0, cnt_err_q, seq_err_q, 4'b0000};

  // R3: clear wins and empties both error bits
  p_clear_empties_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!seq_err_q && !cnt_err_q));

  // R10: error bits are sticky until cleared
  p_sticky_seq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_q && !clr_i) |=> seq_err_q);

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int BUF_DEPTH = 512,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  output logic [1:0]        read_mode_o,
  output logic              op_valid_o,
  output logic [3:0]        op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [15:0]       op_data_o,
  output logic              seq_err_o,
  output logic              cnt_err_o,
  output logic              clr_o,
  output logic              buf_we_o,
  output logic [IDX_W-1:0]  buf_idx_o,
  output logic [15:0]       buf_data_o
);

  localparam logic [16:0] DEPTH_L = 17'(BUF_DEPTH);

  seq_st_e           st_q, st_d;
  rd_mode_e          mode_q, mode_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] oaddr_q, oaddr_d, tgt_q, tgt_d, start_q, start_d;
  logic [15:0]       odata_q, odata_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d, idx_q, idx_d;
  logic [7:0]        cmd;
  logic              same;

  assign cmd  = data_i[7:0];
  assign same = (addr_i == tgt_q);

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    op_d      = OP_NONE;
    oaddr_d   = oaddr_q;
    odata_d   = odata_q;
    tgt_d     = tgt_q;
    start_d   = start_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    seq_err_o = 1'b0;
    cnt_err_o = 1'b0;
    clr_o     = 1'b0;
    if (wr_en_i) begin
      unique case (st_q)
        S_IDLE: begin
          tgt_d = addr_i;
          case (cmd)
            C_ARRAY:   mode_d = RM_ARRAY;
            C_ID:      mode_d = RM_ID;
            C_QUERY:   mode_d = RM_QUERY;
            C_STATUS:  mode_d = RM_STATUS;
            C_CLEAR:   clr_o = 1'b1;
            C_SUSPEND, C_CONFIRM: begin
              op_d    = (cmd == C_SUSPEND) ? OP_SUSPEND : OP_RESUME;
              oaddr_d = addr_i;
              odata_d = '0;
              mode_d  = RM_STATUS;
            end
            C_WPROG:   begin st_d = S_PROG;  mode_d = RM_STATUS; end
            C_ERASE:   begin st_d = S_ERASE; mode_d = RM_STATUS; end
            C_BLANK:   begin st_d = S_BLANK; mode_d = RM_STATUS; end
            C_OTP:     begin st_d = S_OTP;   mode_d = RM_STATUS; end
            C_BUF:     begin st_d = S_BCNT;  mode_d = RM_STATUS; end
            C_CFG:     st_d = S_CFG;
            default: ;
          endcase
        end
        S_PROG, S_OTP: begin
          st_d = S_IDLE;
          if (same) begin
            op_d    = (st_q == S_PROG) ? OP_PROG : OP_OTP;
            oaddr_d = addr_i;
            odata_d = data_i;
          end else seq_err_o = 1'b1;
        end
        S_ERASE, S_BLANK: begin
          st_d = S_IDLE;
          if (same && cmd == C_CONFIRM) begin
            op_d    = (st_q == S_ERASE) ? OP_ERASE : OP_BLANK;
            oaddr_d = addr_i;
            odata_d = '0;
          end else seq_err_o = 1'b1;
        end
        S_CFG: begin
          st_d    = S_IDLE;
          oaddr_d = addr_i;
          odata_d = '0;
          if (!same) seq_err_o = 1'b1;
          else begin
            case (cmd)
              C_LOCK:    op_d = OP_LOCK;
              C_CONFIRM: op_d = OP_UNLOCK;
              C_LOCKDN:  op_d = OP_LOCKDOWN;
              C_RDCFG: begin
                op_d    = OP_RDCFG;
                odata_d = addr_i[16:1];
              end
              default:   seq_err_o = 1'b1;
            endcase
          end
        end
        S_BCNT: begin
          if (!same) begin
            seq_err_o = 1'b1;
          end else if ({1'b0, data_i} >= DEPTH_L) begin
            cnt_err_o = 1'b1;
          end else begin
            cnt_d = data_i[IDX_W-1:0];
            idx_d = '0;
            st_d  = S_BDATA;
          end
        end
        S_BDATA: begin
          if (idx_q == '0) start_d = addr_i;
          idx_d = idx_q + IDX_W'(1);
          if (idx_q == cnt_q) st_d = S_BCONF;
        end
        S_BCONF: begin
          st_d = S_IDLE;
          if (cmd == C_CONFIRM) begin
            op_d    = OP_BUFPROG;
            oaddr_d = start_q;
            odata_d = 16'(cnt_q);
          end else seq_err_o = 1'b1;
        end
        default: st_d = S_IDLE;
      endcase
      if (seq_err_o || cnt_err_o) begin
        st_d   = S_IDLE;
        mode_d = RM_STATUS;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      mode_q  <= RM_ARRAY;
      op_q    <= OP_NONE;
      oaddr_q <= '0;
      odata_q <= '0;
      tgt_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      op_q    <= op_d;
      oaddr_q <= oaddr_d;
      odata_q <= odata_d;
      tgt_q   <= tgt_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  assign buf_we_o    = wr_en_i && (st_q == S_BDATA);
  assign buf_idx_o   = idx_q;
  assign buf_data_o  = data_i;
  assign read_mode_o = mode_q;
  assign op_valid_o  = (op_q != OP_NONE);
  assign op_code_o   = op_q;
  assign op_addr_o   = oaddr_q;
  assign op_data_o   = odata_q;

  // R13: an op pulse is always the answer to a write one cycle earlier
  p_op_after_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(wr_en_i));

  // R9: data index never passes the announced count
  p_idx_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_BDATA) |-> (idx_q <= cnt_q));

  // R11: oversized count returns to idle with no op and no buffer write
  p_cnt_reject_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && st_q == S_BCNT && same && {1'b0, data_i} >= DEPTH_L)
      |=> (st_q == S_IDLE && !op_valid_o && !buf_we_o));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int ADDR_W    = 25,
  parameter int BUF_DEPTH = 512,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              busy_i,
  output logic [1:0]        read_mode_o,
  output logic [7:0]        status_o,
  output logic              op_valid_o,
  output logic [3:0]        op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [15:0]       op_data_o,
  input  logic [IDX_W-1:0]  buf_rd_idx_i,
  output logic [15:0]       buf_rd_data_o
);

  logic             seq_err, cnt_err, clr;
  logic             buf_we;
  logic [IDX_W-1:0] buf_idx;
  logic [15:0]      buf_data;

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .read_mode_o (read_mode_o),
    .op_valid_o  (op_valid_o),
    .op_code_o   (op_code_o),
    .op_addr_o   (op_addr_o),
    .op_data_o   (op_data_o),
    .seq_err_o   (seq_err),
    .cnt_err_o   (cnt_err),
    .clr_o       (clr),
    .buf_we_o    (buf_we),
    .buf_idx_o   (buf_idx),
    .buf_data_o  (buf_data)
  );

  nor_status_reg i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .set_seq_i (seq_err),
    .set_cnt_i (cnt_err),
    .clr_i     (clr),
    .status_o  (status_o)
  );

  nor_wbuf #(.DEPTH(BUF_DEPTH)) i_wbuf (
    .clk_i     (clk_i),
    .we_i      (buf_we),
    .wr_idx_i  (buf_idx),
    .wr_data_i (buf_data),
    .rd_idx_i  (buf_rd_idx_i),
    .rd_data_o (buf_rd_data_o)
  );

  // R10: a fresh sequence error always leaves the read mode on status
  p_err_to_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) |-> (read_mode_o == 2'd3));

  // R11: a fresh count error also leaves the read mode on status
  p_cnt_to_status_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> (read_mode_o == 2'd3 && !op_valid_o));

endmodule

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
  localparam int AW = 25;
  localparam int DEPTH = 8;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [1:0] rmode;
  logic [7:0] status;
  logic op_v;
  logic [3:0] op_c;
  logic [AW-1:0] op_a;
  logic [15:0] op_d, rd_data;

  always #2.5 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(AW), .BUF_DEPTH(DEPTH)) i_nor_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .busy_i(busy), .read_mode_o(rmode), .status_o(status), .op_valid_o(op_v),
    .op_code_o(op_c), .op_addr_o(op_a), .op_data_o(op_d),
    .buf_rd_idx_i(rd_idx), .buf_rd_data_o(rd_data));

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  int m_st = 0, e_mode = 0, e_code = 0, m_cnt = 0, m_idx = 0;
  bit e_seq = 0, e_cnt = 0, e_opv = 0;
  logic [AW-1:0] m_tgt = '0, m_start = '0, e_addr = '0;
  logic [15:0] e_data = '0;
  logic [15:0] ref_buf [DEPTH];

  task automatic put_op(int c, logic [AW-1:0] a, logic [15:0] d);
    e_opv = 1; e_code = c; e_addr = a; e_data = d;
  endtask

  task automatic set_err(bit cnt);
    if (cnt) e_cnt = 1; else e_seq = 1;
    e_mode = 3; m_st = 0;
  endtask

  task automatic model_step(bit we, logic [AW-1:0] a, logic [15:0] d);
    logic [7:0] c;
    c = d[7:0];
    e_opv = 0;
    if (!we) return;
    case (m_st)
      0: begin
        m_tgt = a;
        if (c == 8'hFF) e_mode = 0;
        else if (c == 8'h90) e_mode = 1;
        else if (c == 8'h98) e_mode = 2;
        else if (c == 8'h70) e_mode = 3;
        else if (c == 8'h50) begin e_seq = 0; e_cnt = 0; end
        else if (c == 8'hB0) begin put_op(10, a, 0); e_mode = 3; end
        else if (c == 8'hD0) begin put_op(11, a, 0); e_mode = 3; end
        else if (c == 8'h40) begin m_st = 1; e_mode = 3; end
        else if (c == 8'h20) begin m_st = 2; e_mode = 3; end
        else if (c == 8'hBC) begin m_st = 3; e_mode = 3; end
        else if (c == 8'hC0) begin m_st = 5; e_mode = 3; end
        else if (c == 8'hE8) begin m_st = 6; e_mode = 3; end
        else if (c == 8'h60) m_st = 4;
      end
      1, 5: begin
        if (a != m_tgt) set_err(0);
        else begin put_op(m_st == 1 ? 1 : 8, a, d); m_st = 0; end
      end
      2, 3: begin
        if (a != m_tgt || c != 8'hD0) set_err(0);
        else begin put_op(m_st == 2 ? 2 : 3, a, 0); m_st = 0; end
      end
      4: begin
        m_st = 0;
        if (a != m_tgt) set_err(0);
        else if (c == 8'h01) put_op(4, a, 0);
        else if (c == 8'hD0) put_op(5, a, 0);
        else if (c == 8'h2F) put_op(6, a, 0);
        else if (c == 8'h03) put_op(7, a, a[16:1]);
        else set_err(0);
      end
      6: begin
        if (a != m_tgt) set_err(0);
        else if (int'(d) >= DEPTH) set_err(1);
        else begin m_cnt = int'(d); m_idx = 0; m_st = 7; end
      end
      7: begin
        if (m_idx == 0) m_start = a;
        ref_buf[m_idx] = d;
        if (m_idx == m_cnt) m_st = 8;
        m_idx++;
      end
      8: begin
        if (c == 8'hD0) begin put_op(9, m_start, 16'(m_cnt)); m_st = 0; end
        else set_err(0);
      end
      default: m_st = 0;
    endcase
  endtask

  task automatic compare();
    logic [7:0] e_stat;
    bit bad;
    e_stat = {~busy, 1'b0, e_cnt, e_seq, 4'b0000};
    bad = (rmode != 2'(e_mode)) || (status != e_stat) || (op_v != e_opv);
    if (e_opv && (op_c != 4'(e_code) || op_a != e_addr || op_d != e_data)) bad = 1;
    tests++;
    if (bad) begin
      fails++;
      $display("FAIL %s: mode=%0d st=%h v=%0d code=%0d a=%h d=%h exp mode=%0d st=%h v=%0d code=%0d a=%h d=%h",
               cur_req, rmode, status, op_v, op_c, op_a, op_d,
               e_mode, e_stat, e_opv, e_code, e_addr, e_data);
    end
  endtask

  task automatic cyc(bit we, logic [AW-1:0] a, logic [15:0] d);
    wr_en = we; addr = a; data = d;
    @(posedge clk);
    #1 model_step(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    compare();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0);
  endtask

  task automatic check_buf(int n);
    for (int i = 0; i < n; i++) begin
      rd_idx = IW'(i);
      #1;
      tests++;
      if (rd_data !== ref_buf[i]) begin
        fails++;
        $display("FAIL %s: buf[%0d]=%h exp %h", cur_req, i, rd_data, ref_buf[i]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ba, cfg_a;
    for (int i = 0; i < DEPTH; i++) ref_buf[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(2);
    // prefill buffer so later checks have known contents
    cur_req = "R9"; ba = 25'h0001000;
    wr(ba, 16'h00E8); wr(ba, 16'd7);
    for (int i = 0; i < DEPTH; i++) wr(ba + AW'(i), 16'hA000 + 16'(i));
    wr(ba, 16'h00D0); idle(1); check_buf(DEPTH);
    cur_req = "R2";
    wr(25'h10, 16'h0090); wr(25'h10, 16'h0098); wr(25'h10, 16'h0070);
    wr(25'h10, 16'h00FF); wr(25'h10, 16'h3398); wr(25'h10, 16'hFFFF);
    cur_req = "R13"; wr(25'h10, 16'h0012); wr(25'h10, 16'h00A5); idle(1);
    cur_req = "R4"; wr(25'h1234, 16'h0040); wr(25'h1234, 16'hBEEF); idle(1);
    cur_req = "R5"; wr(25'h40000, 16'h0020); wr(25'h40000, 16'h00D0);
    wr(25'h40002, 16'h00BC); wr(25'h40002, 16'h00D0); idle(1);
    cur_req = "R6"; cfg_a = 25'h0002469;
    wr(cfg_a, 16'h0060); wr(cfg_a, 16'h0001);
    wr(cfg_a, 16'h0060); wr(cfg_a, 16'h00D0);
    wr(cfg_a, 16'h0060); wr(cfg_a, 16'h002F);
    wr(cfg_a, 16'h0060); wr(cfg_a, 16'h0003); idle(1);
    cur_req = "R7"; wr(25'h77, 16'h00B0); wr(25'h77, 16'h00D0);
    cur_req = "R8"; wr(25'h80, 16'h00C0); wr(25'h80, 16'h5A5A);
    cur_req = "R10"; wr(25'h99, 16'h0020); wr(25'h99, 16'h0011);
    cur_req = "R3"; wr(25'h0, 16'h00FF); wr(25'h0, 16'h0050); idle(1);
    cur_req = "R10"; wr(25'h99, 16'h0040); wr(25'h9A, 16'h1111);
    wr(25'h5, 16'h0060); wr(25'h5, 16'h0077);
    wr(25'h5, 16'h00E8); wr(25'h5, 16'h0000); wr(25'h6, 16'h4444); wr(25'h6, 16'h00FF);
    wr(25'h0, 16'h0050);
    cur_req = "R11"; wr(25'h20, 16'h00FF); wr(25'h20, 16'h00E8); wr(25'h20, 16'd8);
    wr(25'h21, 16'h9999); idle(1); check_buf(DEPTH);
    wr(25'h20, 16'h00E8); wr(25'h20, 16'hFFFF); idle(1);
    cur_req = "R3"; wr(25'h0, 16'h0050);
    cur_req = "R9"; wr(25'h300, 16'h00E8); wr(25'h300, 16'd0);
    wr(25'h345, 16'hC0DE); wr(25'h300, 16'h00D0); idle(1); check_buf(DEPTH);
    wr(25'h400, 16'h00E8); wr(25'h400, 16'd2);
    wr(25'h410, 16'h1111); wr(25'h411, 16'h2222); wr(25'h412, 16'h3333);
    wr(25'h400, 16'h00D0); check_buf(3);
    cur_req = "R12"; busy = 1'b1; idle(2); busy = 1'b0; idle(1);
    cur_req = "R13"; wr(25'h1, 16'h0090); idle(1); wr(25'h1, 16'h0000); idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule